// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block performs one atomic read-modify-write at a time on a single-port, word-wide memory. A request gives a byte address, a source operand, a destination register index, an operation code, a width select and two ordering flags. The unit reads the addressed memory word and returns the old value as the register result. It then combines that old value with the source operand and writes the result back. The memory lock stays asserted from the read to the write-back, so no other agent can reach memory in between.

Requests are either full-width or half-width. With the default 64-bit datapath these are 64-bit and 32-bit operations. A half-width operation works on one half of the memory word and returns its old value sign-extended. A misaligned address ends the request with an exception flag and makes no memory access. The ordering flags are not used in the datapath. They are handed to an external ordering unit alongside the result.

The memory is expected to return read data one cycle after a read request. It writes on the clock edge at which a write request with byte enables is presented.

Top module: `amo_unit`

## Requirements
- R1: Operation codes are 0 swap (new = src), 1 add, 2 AND, 3 OR, 4 XOR, 5 signed max, 6 signed min, 7 unsigned max, 8 unsigned min. The word written back is the operator applied to the old memory value and the source operand.
- R2: resp_data carries the memory value read before the update. For a full-width request it is the whole word. For a half-width request it is the selected half sign-extended to XLEN.
- R3: A half-width request (req_wide = 0) selects the upper half of the word when address bit log2(XLEN/8)-1 (bit 2 at XLEN = 64) is 1, and the lower half otherwise. The write-back enables only that half's bytes, so the other half of memory is unchanged. Signed and unsigned compares use only the selected half.
- R4: A full-width request whose address is not XLEN/8-byte aligned, or a half-width request that is not XLEN/16-byte aligned, is a misaligned request. It makes no memory access. It completes with resp_misaligned = 1 and resp_wb = 0.
- R5: mem_lock is high in every cycle from the read request through the write request, and every memory access happens inside that window. req_ready is low whenever the unit is not idle.
- R6: When the destination index is 0, resp_wb is 0 and resp_data is 0, and memory is still updated. Otherwise, on a clean completion, resp_wb is 1.
- R7: The ordering flags appear unchanged on resp_aq and resp_rl alongside resp_done. They have no effect on the returned value or on the written word.
- R8: Operation codes 9 to 15 write the old value back unchanged and still return the old value.
- R9: resp_done is a one-cycle pulse. For an aligned request it comes 4 cycles after the accepting edge. For a misaligned request it comes 1 cycle after.
- R10: After reset, req_ready is 1 and mem_req, mem_lock and resp_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_addr | input | AW | Byte address |
| req_src | input | XLEN | Source operand |
| req_rd | input | RIW | Destination register index |
| req_op | input | 4 | Operation code |
| req_wide | input | 1 | 1 = full width, 0 = half width |
| req_aq | input | 1 | Acquire flag |
| req_rl | input | 1 | Release flag |
| mem_lock | output | 1 | Memory reserved for this operation |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | XLEN/8 | Byte enables for writes |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid one cycle after a read request |
| resp_done | output | 1 | Completion pulse |
| resp_wb | output | 1 | Register write-back valid |
| resp_rd | output | RIW | Destination register index |
| resp_data | output | XLEN | Old memory value, extended |
| resp_misaligned | output | 1 | Misaligned-address exception |
| resp_aq | output | 1 | Acquire flag of the completed request |
| resp_rl | output | 1 | Release flag of the completed request |

## Verification
The bench builds the unit with XLEN = 64, AW = 16 and RIW = 5. With these values both widths are reachable in one build. Half-width operations hit both halves of a word, and sign extension of the half-width result into the upper 32 bits becomes visible. Memory is a 16-word array with a reference copy. Operands are chosen so that signed and unsigned compares disagree at both widths. The alignment check is driven at offsets 1 to 7.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_MODIFY = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } amo_state_e;

  typedef enum logic [3:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_MAX  = 4'd5,
    OP_MIN  = 4'd6,
    OP_MAXU = 4'd7,
    OP_MINU = 4'd8
  } amo_op_e;

  // Signed and unsigned codes share a compare; this picks the signed flavour.
  function automatic logic op_is_signed(input logic [3:0] op);
    return (op == OP_MAX) || (op == OP_MIN);
  endfunction

endpackage

// File: rtl/amo_align.sv
module amo_align #(
  parameter int AW   = 16,
  parameter int XLEN = 64
) (
  input  logic [AW-1:0] addr,
  input  logic          wide,
  output logic          misaligned
);
  localparam int BYTES  = XLEN / 8;
  localparam int OFF_W  = $clog2(BYTES);
  localparam int HOFF_W = OFF_W - 1;

  logic [OFF_W-1:0] off;
  logic             full_bad;
  logic             half_bad;

  assign off      = addr[OFF_W-1:0];
  assign full_bad = |off;
  assign half_bad = |off[HOFF_W-1:0];

  assign misaligned = wide ? full_bad : half_bad;
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]        op,
  input  logic              wide,
  input  logic              hsel,
  input  logic [XLEN-1:0]   old_word,
  input  logic [XLEN-1:0]   src,
  output logic [XLEN-1:0]   new_word,
  output logic [XLEN/8-1:0] be,
  output logic [XLEN-1:0]   ret
);
  localparam int HALF  = XLEN / 2;
  localparam int BYTES = XLEN / 8;
  localparam int HB    = BYTES / 2;

  // Operator on two XLEN-wide operands; a and b arrive already extended.
  function automatic logic [XLEN-1:0] combine(input logic [3:0] code,
                                              input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b);
    logic s_lt;
    logic u_lt;
    s_lt = $signed(a) < $signed(b);
    u_lt = a < b;
    case (code)
      OP_SWAP: return b;
      OP_ADD:  return a + b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_MAX:  return s_lt ? b : a;
      OP_MIN:  return s_lt ? a : b;
      OP_MAXU: return u_lt ? b : a;
      OP_MINU: return u_lt ? a : b;
      default: return a;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] extend_half(input logic [HALF-1:0] h,
                                                  input logic sgn);
    return {{HALF{sgn & h[HALF-1]}}, h};
  endfunction

  logic [HALF-1:0] old_half;
  logic [XLEN-1:0] a_ext;
  logic [XLEN-1:0] b_ext;
  logic [XLEN-1:0] result;
  logic            sgn;

  assign sgn      = op_is_signed(op);
  assign old_half = hsel ? old_word[XLEN-1:HALF] : old_word[HALF-1:0];

  always_comb begin
    if (wide) begin
      a_ext = old_word;
      b_ext = src;
    end else begin
      a_ext = extend_half(old_half, sgn);
      b_ext = extend_half(src[HALF-1:0], sgn);
    end
    result = combine(op, a_ext, b_ext);
  end

  always_comb begin
    if (wide) begin
      new_word = result;
      be       = '1;
      ret      = old_word;
    end else begin
      ret = extend_half(old_half, 1'b1);
      if (hsel) begin
        new_word = {result[HALF-1:0], old_word[HALF-1:0]};
        be       = {{HB{1'b1}}, {HB{1'b0}}};
      end else begin
        new_word = {old_word[XLEN-1:HALF], result[HALF-1:0]};
        be       = {{HB{1'b0}}, {HB{1'b1}}};
      end
    end
  end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       fault,
  output amo_state_e state
);
  amo_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start) nxt = fault ? ST_DONE : ST_READ;
      ST_READ:   nxt = ST_MODIFY;
      ST_MODIFY: nxt = ST_WRITE;
      ST_WRITE:  nxt = ST_DONE;
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 16,
  parameter int RIW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [XLEN-1:0]   req_src,
  input  logic [RIW-1:0]    req_rd,
  input  logic [3:0]        req_op,
  input  logic              req_wide,
  input  logic              req_aq,
  input  logic              req_rl,
  output logic              mem_lock,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [XLEN/8-1:0] mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              resp_done,
  output logic              resp_wb,
  output logic [RIW-1:0]    resp_rd,
  output logic [XLEN-1:0]   resp_data,
  output logic              resp_misaligned,
  output logic              resp_aq,
  output logic              resp_rl
);
  localparam int BYTES = XLEN / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int IDX_W = AW - OFF_W;

  amo_state_e state;

  // Named internal events
  logic ev_accept;
  logic ev_fault;
  logic ev_capture;
  logic ev_write;
  logic misaligned;

  logic [IDX_W-1:0] idx_q;
  logic             hsel_q;
  logic [XLEN-1:0]  src_q;
  logic [RIW-1:0]   rd_q;
  logic [3:0]       op_q;
  logic             wide_q;
  logic             aq_q;
  logic             rl_q;
  logic             fault_q;
  logic [XLEN-1:0]  ret_q;
  logic [XLEN-1:0]  new_q;
  logic [BYTES-1:0] be_q;

  logic [XLEN-1:0]  alu_new;
  logic [BYTES-1:0] alu_be;
  logic [XLEN-1:0]  alu_ret;

  amo_align #(.AW(AW), .XLEN(XLEN)) u_align (
    .addr       (req_addr),
    .wide       (req_wide),
    .misaligned (misaligned)
  );

  amo_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_accept),
    .fault (misaligned),
    .state (state)
  );

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op       (op_q),
    .wide     (wide_q),
    .hsel     (hsel_q),
    .old_word (mem_rdata),
    .src      (src_q),
    .new_word (alu_new),
    .be       (alu_be),
    .ret      (alu_ret)
  );

  assign req_ready  = (state == ST_IDLE);
  assign ev_accept  = req_valid && req_ready;
  assign ev_fault   = ev_accept && misaligned;
  assign ev_capture = (state == ST_MODIFY);
  assign ev_write   = (state == ST_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      hsel_q  <= 1'b0;
      src_q   <= '0;
      rd_q    <= '0;
      op_q    <= '0;
      wide_q  <= 1'b0;
      aq_q    <= 1'b0;
      rl_q    <= 1'b0;
      fault_q <= 1'b0;
    end else if (ev_accept) begin
      idx_q   <= req_addr[AW-1:OFF_W];
      hsel_q  <= req_addr[OFF_W-1];
      src_q   <= req_src;
      rd_q    <= req_rd;
      op_q    <= req_op;
      wide_q  <= req_wide;
      aq_q    <= req_aq;
      rl_q    <= req_rl;
      fault_q <= misaligned;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q <= '0;
      new_q <= '0;
      be_q  <= '0;
    end else if (ev_capture) begin
      ret_q <= alu_ret;
      new_q <= alu_new;
      be_q  <= alu_be;
    end
  end

  assign mem_lock  = (state == ST_READ) || ev_capture || ev_write;
  assign mem_req   = (state == ST_READ) || ev_write;
  assign mem_we    = ev_write;
  assign mem_addr  = {idx_q, {OFF_W{1'b0}}};
  assign mem_be    = ev_write ? be_q : '0;
  assign mem_wdata = new_q;

  assign resp_done       = (state == ST_DONE);
  assign resp_misaligned = resp_done && fault_q;
  assign resp_wb         = resp_done && !fault_q && (rd_q != '0);
  assign resp_data       = resp_wb ? ret_q : '0;
  assign resp_rd         = rd_q;
  assign resp_aq         = aq_q;
  assign resp_rl         = rl_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int XLEN = 64,
  parameter int RIW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_lock,
  input logic              mem_req,
  input logic              mem_we,
  input logic [XLEN/8-1:0] mem_be,
  input logic              resp_done,
  input logic              resp_wb,
  input logic [RIW-1:0]    resp_rd,
  input logic              resp_misaligned,
  input logic              ev_fault
);
  localparam int BYTES = XLEN / 8;

  AST_ACCESS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> !req_ready); // R5
  AST_WRITE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_lock)); // R5
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> (resp_done && !mem_req && resp_misaligned)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done); // R9
  AST_WB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    resp_wb |-> (resp_rd != '0 && !resp_misaligned)); // R6
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == BYTES || $countones(mem_be) == BYTES/2)); // R3
endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN), .RIW(RIW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_ready       (req_ready),
  .mem_lock        (mem_lock),
  .mem_req         (mem_req),
  .mem_we          (mem_we),
  .mem_be          (mem_be),
  .resp_done       (resp_done),
  .resp_wb         (resp_wb),
  .resp_rd         (resp_rd),
  .resp_misaligned (resp_misaligned),
  .ev_fault        (ev_fault)
);

// File: tb/tb_amo_unit.sv
`timescale 1ns/1ps
module tb_amo_unit;
  localparam int XLEN = 64;
  localparam int AW   = 16;
  localparam int RIW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [AW-1:0]   req_addr = '0;
  logic [63:0]     req_src = '0;
  logic [RIW-1:0]  req_rd = '0;
  logic [3:0]      req_op = '0;
  logic            req_wide = 1'b0;
  logic            req_aq = 1'b0;
  logic            req_rl = 1'b0;
  logic            mem_lock, mem_req, mem_we;
  logic [AW-1:0]   mem_addr;
  logic [7:0]      mem_be;
  logic [63:0]     mem_wdata;
  logic [63:0]     mem_rdata;
  logic            resp_done, resp_wb, resp_misaligned, resp_aq, resp_rl;
  logic [RIW-1:0]  resp_rd;
  logic [63:0]     resp_data;

  amo_unit #(.XLEN(XLEN), .AW(AW), .RIW(RIW)) dut (.*);

  logic [63:0] mem [16];
  logic [63:0] refm [16];
  int access_cnt = 0;
  int n_checks = 0;
  int n_fail = 0;

  always @(posedge clk) begin
    if (mem_req) begin
      access_cnt <= access_cnt + 1;
      if (mem_we) begin
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) mem[mem_addr[6:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[6:3]];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference: new 32-bit or 64-bit value, written independently of the RTL.
  function automatic logic [63:0] ref_apply(input logic [3:0] op,
      input logic [63:0] o, input logic [63:0] s, input bit w);
    logic [63:0] r;
    if (w) begin
      case (op)
        0: r = s;  1: r = o + s;  2: r = o & s;  3: r = o | s;  4: r = o ^ s;
        5: r = ($signed(o) > $signed(s)) ? o : s;
        6: r = ($signed(o) > $signed(s)) ? s : o;
        7: r = (o > s) ? o : s;
        8: r = (o > s) ? s : o;
        default: r = o;
      endcase
    end else begin
      logic [31:0] a, b, q;
      a = o[31:0]; b = s[31:0];
      case (op)
        0: q = b;  1: q = a + b;  2: q = a & b;  3: q = a | b;  4: q = a ^ b;
        5: q = ($signed(a) > $signed(b)) ? a : b;
        6: q = ($signed(a) > $signed(b)) ? b : a;
        7: q = (a > b) ? a : b;
        8: q = (a > b) ? b : a;
        default: q = a;
      endcase
      r = {32'h0, q};
    end
    return r;
  endfunction

  task automatic do_amo(input logic [3:0] op, input logic [AW-1:0] addr,
                        input logic [63:0] src, input logic [RIW-1:0] rd,
                        input bit wide, input bit aq, input bit rl, input string req);
    int lat;
    bit bad_lock;
    bit mis;
    int acc0;
    logic [3:0]  w;
    logic [63:0] old, nw, exp_ret;
    logic [31:0] oh;
    w = addr[6:3];
    mis = wide ? (addr[2:0] != 0) : (addr[1:0] != 0);
    old = refm[w];
    if (wide) begin
      exp_ret = old;
      nw = ref_apply(op, old, src, 1);
    end else begin
      oh = addr[2] ? old[63:32] : old[31:0];
      exp_ret = {{32{oh[31]}}, oh};
      nw = ref_apply(op, {32'h0, oh}, src, 0);
      nw = addr[2] ? {nw[31:0], old[31:0]} : {old[63:32], nw[31:0]};
    end
    if (!mis) refm[w] = nw;
    @(negedge clk);
    acc0 = access_cnt;
    req_valid = 1; req_addr = addr; req_src = src; req_rd = rd; req_op = op;
    req_wide = wide; req_aq = aq; req_rl = rl;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_aq = ~aq; req_rl = ~rl;
    lat = 1; bad_lock = 0;
    while (!resp_done && lat < 10) begin
      if (req_ready || (mem_req && !mem_lock)) bad_lock = 1;
      @(negedge clk); lat++;
    end
    check(lat == (mis ? 1 : 4), "R9 latency", lat, mis ? 1 : 4);
    check(!bad_lock, "R5 lock/ready while busy", bad_lock, 0);
    check(resp_misaligned == mis, "R4 exception flag", resp_misaligned, mis);
    if (mis) begin
      check(access_cnt == acc0 && !resp_wb, "R4 no access", access_cnt - acc0, 0);
    end else if (rd == 0) begin
      check(!resp_wb && resp_data == 0, {"R6 rd0 ", req}, resp_data, 0);
    end else begin
      check(resp_wb && resp_data == exp_ret, {"R2 old value ", req}, resp_data, exp_ret);
    end
    check(resp_aq == aq && resp_rl == rl, "R7 order flags", {resp_aq, resp_rl}, {aq, rl});
    check(resp_rd == rd, "R6 rd echo", resp_rd, rd);
    @(negedge clk);
    check(!resp_done, "R9 done pulse", resp_done, 0);
    check(mem[w] == refm[w], {"R1 memory ", req}, mem[w], refm[w]);
  endtask

  task automatic t_reset();
    check(req_ready && !mem_req && !mem_lock && !resp_done, "R10 reset state",
          {req_ready, mem_req, mem_lock, resp_done}, 4'b1000);
  endtask

  task automatic t_wide_ops();
    for (int op = 0; op < 9; op++) begin
      do_amo(4'(op), 16'(op * 8), 64'h8000_0000_0000_0005, 5'd3, 1, 0, 0, "R1 wide");
      do_amo(4'(op), 16'(op * 8), 64'h0000_0000_0000_0007, 5'd4, 1, 0, 0, "R1 wide pos");
    end
  endtask

  task automatic t_narrow_ops();
    for (int op = 0; op < 9; op++) begin
      do_amo(4'(op), 16'(op * 8 + 4), 64'hDEAD_0000_8000_0009, 5'd7, 0, 0, 0, "R3 upper");
      do_amo(4'(op), 16'(op * 8), 64'h1111_2222_7FFF_FFF0, 5'd8, 0, 0, 0, "R3 lower");
    end
  endtask

  task automatic t_misaligned();
    for (int off = 1; off < 8; off++)
      do_amo(4'd1, 16'(80 + off), 64'd1, 5'd2, 1, 0, 0, "R4 wide");
    do_amo(4'd1, 16'd86, 64'd1, 5'd2, 0, 0, 0, "R4 half");
    do_amo(4'd1, 16'd84, 64'd1, 5'd2, 0, 0, 0, "R4 half ok");
  endtask

  task automatic t_misc();
    do_amo(4'd1, 16'd96, 64'd100, 5'd0, 1, 0, 0, "R6 wide");
    do_amo(4'd5, 16'd100, 64'hFFFF_FFFF, 5'd0, 0, 0, 0, "R6 half");
    do_amo(4'd1, 16'd104, 64'd9, 5'd1, 1, 1, 0, "R7 aq");
    do_amo(4'd1, 16'd104, 64'd9, 5'd1, 1, 0, 1, "R7 rl");
    do_amo(4'd6, 16'd108, 64'h8000_0000, 5'd1, 0, 1, 1, "R7 both");
    do_amo(4'd12, 16'd112, 64'hFFFF, 5'd6, 1, 0, 0, "R8 bad code");
    do_amo(4'd15, 16'd116, 64'hFFFF, 5'd6, 0, 0, 0, "R8 bad code half");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]  = {4'(i) ^ 4'h9, 28'h1234567, 32'h0} ^ (64'(i) * 64'h0F0F_0F0F_8765_4321);
      refm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wide_ops();
    t_narrow_ops();
    t_misaligned();
    t_misc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #150000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule